// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a seconds and sub-seconds time of day for precision time protocol timestamping. It runs on the reference clock. Software programs it through a small synchronous register port. The sub-second field either counts true nanoseconds and wraps at one billion, or counts binary fractions and wraps at 2^31. Each wrap carries into the seconds field.

The clock rate can be trimmed in two ways. In coarse mode the time advances by a programmed increment on every reference clock. In fine mode a 32-bit phase accumulator adds a working addend on every clock, and the time advances by the increment only on the clocks where that accumulator overflows. Software can change the addend without stopping the time.

Three self-clearing command bits change the time or the rate, and software polls them until they clear:
- the load command sets the time outright;
- the adjust command adds or subtracts an offset;
- the addend command makes a new addend take effect.

A subtract is requested through complement encoding. The seconds operand is the 2^32 complement of the amount. The sub-second operand is the rollover value minus the amount. The block folds the sub-second carry or borrow into the seconds field in the same cycle.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset every register reads zero: control, increment, addend, both update registers and both time registers.
- R2: In coarse mode (control bit 0 clear), when no wrap occurs the sub-second field grows by the increment register (address 1, bits 7:0) on each clock. An increment written in one cycle is used from the next clock on.
- R3: In fine mode (control bit 0 set), a 32-bit accumulator adds the working addend on each clock. The time advances by the increment only on an accumulator overflow. A value written to the addend register (address 2) has no effect until the addend command (control bit 4) has been applied.
- R4: With digital rollover (control bit 1 set), a sub-second sum of 1,000,000,000 or more has that value taken off and adds one to the seconds.
- R5: With binary rollover (control bit 1 clear), a sub-second sum of 2^31 or more has 2^31 taken off and adds one to the seconds.
- R6: The load command (control bit 2) replaces the seconds with the update-seconds register (address 3) and the sub-seconds with bits 30:0 of the update-sub-seconds register (address 4).
- R7: The adjust command (control bit 3) with update bit 31 clear adds the update seconds and sub-seconds to the time. A sub-second wrap adds one more second.
- R8: The adjust command with update bit 31 set treats the operands as complements. If the sub-second sum wraps, the seconds become seconds plus update seconds. Otherwise they become that sum minus one, and the sub-seconds keep the unwrapped sum.
- R9: A command bit is set by writing 1 to it; writing 0 leaves it unchanged. Bits 1:0 of the same write set the modes. Only one command is in progress at a time, chosen by priority load, then adjust, then addend; the others wait with their bits still set. A command takes effect on the clock after its bit is seen set, and its bit clears on the clock after that.
- R10: Reads are combinational and use these addresses:
  - 0: control, bits 4:0;
  - 1: increment;
  - 2: addend;
  - 3: update seconds;
  - 4: update sub-seconds, with the subtract flag in bit 31;
  - 5: time sub-seconds;
  - 6: time seconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |

## Verification
The assertions check, on every cycle:
- the step size in coarse mode;
- that the time stays frozen on fine-mode cycles without an accumulator overflow;
- that the seconds move by at most one outside commands;
- the exact result of a load;
- the one-cycle clear of the load bit.

Only the bench's scenarios can show the following, because they depend on chosen operand values and command orderings:
- the arithmetic of an adjust, including complement subtraction with and without a borrow;
- the exact cycle of a rollover in each mode;
- the rate of advance for a given addend;
- a queued command waiting behind a higher-priority one.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_INCR   = 3'd1,
    REG_ADDEND = 3'd2,
    REG_USEC   = 3'd3,
    REG_USUB   = 3'd4,
    REG_TSUB   = 3'd5,
    REG_TSEC   = 3'd6
  } reg_addr_e;

  localparam int unsigned CTL_FINE = 0;
  localparam int unsigned CTL_DIG  = 1;
  localparam int unsigned CTL_CMD0 = 2;
  localparam int unsigned NUM_CMD  = 3;

  localparam int unsigned CMD_LOAD = 0;
  localparam int unsigned CMD_ADJ  = 1;
  localparam int unsigned CMD_ADD  = 2;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_DONE = 1'b1
  } seq_e;

endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned INC_W  = 8,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned SUB_W  = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               fine_mode,
  output logic               digital_mode,
  output logic [INC_W-1:0]   incr,
  output logic [DATA_W-1:0]  addend_reg,
  output logic [SEC_W-1:0]   upd_sec,
  output logic [SUB_W-1:0]   upd_sub,
  output logic               upd_subtract,
  output logic [NUM_CMD-1:0] cmd_pend,
  output logic [NUM_CMD-1:0] cmd_apply
);

  logic [1:0]         mode_q, mode_d;
  logic [NUM_CMD-1:0] cmd_q, cmd_d, cmd_clr, cmd_set;
  logic [NUM_CMD-1:0] op_q, op_d, apply_c;
  seq_e               state_q, state_d;
  logic [INC_W-1:0]   incr_q;
  logic [DATA_W-1:0]  addend_q;
  logic [SEC_W-1:0]   usec_q;
  logic [SUB_W-1:0]   usub_q;
  logic               usubtr_q;

  logic wr_ctrl, wr_incr, wr_addend, wr_usec, wr_usub;

  always_comb begin
    wr_ctrl   = reg_wr && (reg_addr == REG_CTRL);
    wr_incr   = reg_wr && (reg_addr == REG_INCR);
    wr_addend = reg_wr && (reg_addr == REG_ADDEND);
    wr_usec   = reg_wr && (reg_addr == REG_USEC);
    wr_usub   = reg_wr && (reg_addr == REG_USUB);
  end

  // command sequencer: pick one pending command, apply, then clear its bit
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    apply_c = '0;
    cmd_clr = '0;
    case (state_q)
      SEQ_IDLE: begin
        for (int i = NUM_CMD - 1; i >= 0; i--) begin
          if (cmd_q[i]) begin
            apply_c = '0;
            apply_c[i] = 1'b1;
          end
        end
        if (|apply_c) begin
          op_d    = apply_c;
          state_d = SEQ_DONE;
        end
      end
      SEQ_DONE: begin
        cmd_clr = op_q;
        op_d    = '0;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    cmd_set = wr_ctrl ? reg_wdata[CTL_CMD0 +: NUM_CMD] : '0;
    cmd_d   = (cmd_q & ~cmd_clr) | cmd_set;
    mode_d  = reg_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      op_q    <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      cmd_q   <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      incr_q   <= '0;
      addend_q <= '0;
      usec_q   <= '0;
      usub_q   <= '0;
      usubtr_q <= 1'b0;
    end else begin
      if (wr_ctrl)   mode_q   <= mode_d;
      if (wr_incr)   incr_q   <= reg_wdata[INC_W-1:0];
      if (wr_addend) addend_q <= reg_wdata;
      if (wr_usec)   usec_q   <= reg_wdata[SEC_W-1:0];
      if (wr_usub) begin
        usub_q   <= reg_wdata[SUB_W-1:0];
        usubtr_q <= reg_wdata[DATA_W-1];
      end
    end
  end

  assign fine_mode    = mode_q[CTL_FINE];
  assign digital_mode = mode_q[CTL_DIG];
  assign incr         = incr_q;
  assign addend_reg   = addend_q;
  assign upd_sec      = usec_q;
  assign upd_sub      = usub_q;
  assign upd_subtract = usubtr_q;
  assign cmd_pend     = cmd_q;
  assign cmd_apply    = apply_c;

endmodule

// File: rtl/ptp_tod_rate.sv
module ptp_tod_rate #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_mode,
  input  logic             load_addend,
  input  logic [ACC_W-1:0] addend_in,
  output logic             acc_carry,
  output logic             tick
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] addend_q;
  logic             carry_c;
  logic             acc_en;

  always_comb begin
    {carry_c, acc_d} = {1'b0, acc_q} + {1'b0, addend_q};
    acc_en           = fine_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      addend_q <= '0;
    end else begin
      if (acc_en)      acc_q    <= acc_d;
      if (load_addend) addend_q <= addend_in;
    end
  end

  assign acc_carry = fine_mode & carry_c;
  assign tick      = !fine_mode | carry_c;

endmodule

// File: rtl/ptp_tod_time.sv
module ptp_tod_time #(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned SUB_W      = 31,
  parameter int unsigned INC_W      = 8,
  parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [INC_W-1:0] incr,
  input  logic             digital_mode,
  input  logic             do_load,
  input  logic             do_adjust,
  input  logic [SEC_W-1:0] upd_sec,
  input  logic [SUB_W-1:0] upd_sub,
  input  logic             upd_subtract,
  output logic [SEC_W-1:0] time_sec,
  output logic [SUB_W-1:0] time_sub
);

  localparam int unsigned EXT_W = SUB_W + 1;
  localparam logic [EXT_W-1:0] LIM_DIG = EXT_W'(NS_PER_SEC);
  localparam logic [EXT_W-1:0] LIM_BIN = {1'b1, {SUB_W{1'b0}}};

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [EXT_W-1:0] lim, tsum, asum, tfix, afix;
  logic             twrap, awrap;
  logic [SEC_W-1:0] sec_adj;

  always_comb begin
    lim   = digital_mode ? LIM_DIG : LIM_BIN;
    tsum  = {1'b0, sub_q} + (tick ? EXT_W'(incr) : '0);
    twrap = tsum >= lim;
    tfix  = twrap ? tsum - lim : tsum;
    asum  = {1'b0, sub_q} + {1'b0, upd_sub};
    awrap = asum >= lim;
    afix  = awrap ? asum - lim : asum;
    sec_adj = sec_q + upd_sec;
    if (upd_subtract) begin
      if (!awrap) sec_adj = sec_adj - SEC_W'(1);
    end else begin
      if (awrap) sec_adj = sec_adj + SEC_W'(1);
    end
  end

  always_comb begin
    if (do_load) begin
      sec_d = upd_sec;
      sub_d = upd_sub;
    end else if (do_adjust) begin
      sec_d = sec_adj;
      sub_d = afix[SUB_W-1:0];
    end else begin
      sec_d = sec_q + SEC_W'(twrap);
      sub_d = tfix[SUB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else begin
      sec_q <= sec_d;
      sub_q <= sub_d;
    end
  end

  assign time_sec = sec_q;
  assign time_sub = sub_q;

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned INC_W      = 8,
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned SUB_W      = 31,
  parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  logic               fine_mode, digital_mode, upd_subtract;
  logic [INC_W-1:0]   incr;
  logic [DATA_W-1:0]  addend_reg;
  logic [SEC_W-1:0]   upd_sec, time_sec;
  logic [SUB_W-1:0]   upd_sub, time_sub;
  logic [NUM_CMD-1:0] cmd_pend, cmd_apply;
  logic               acc_carry, tick;

  ptp_tod_regs #(.DATA_W(DATA_W), .INC_W(INC_W), .SEC_W(SEC_W), .SUB_W(SUB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .fine_mode(fine_mode), .digital_mode(digital_mode), .incr(incr), .addend_reg(addend_reg),
    .upd_sec(upd_sec), .upd_sub(upd_sub), .upd_subtract(upd_subtract),
    .cmd_pend(cmd_pend), .cmd_apply(cmd_apply)
  );

  ptp_tod_rate #(.ACC_W(DATA_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .fine_mode(fine_mode), .load_addend(cmd_apply[CMD_ADD]),
    .addend_in(addend_reg), .acc_carry(acc_carry), .tick(tick)
  );

  ptp_tod_time #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .NS_PER_SEC(NS_PER_SEC)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .incr(incr), .digital_mode(digital_mode),
    .do_load(cmd_apply[CMD_LOAD]), .do_adjust(cmd_apply[CMD_ADJ]),
    .upd_sec(upd_sec), .upd_sub(upd_sub), .upd_subtract(upd_subtract),
    .time_sec(time_sec), .time_sub(time_sub)
  );

  always_comb begin
    case (reg_addr)
      REG_CTRL:   reg_rdata = DATA_W'({cmd_pend, digital_mode, fine_mode});
      REG_INCR:   reg_rdata = DATA_W'(incr);
      REG_ADDEND: reg_rdata = addend_reg;
      REG_USEC:   reg_rdata = DATA_W'(upd_sec);
      REG_USUB:   reg_rdata = {upd_subtract, (DATA_W-1)'(upd_sub)};
      REG_TSUB:   reg_rdata = DATA_W'(time_sub);
      REG_TSEC:   reg_rdata = DATA_W'(time_sec);
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ptp_tod_checker.sv
module ptp_tod_checker #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 31,
  parameter int unsigned INC_W = 8,
  parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fine_mode,
  input logic             digital_mode,
  input logic [INC_W-1:0] incr,
  input logic [2:0]       cmd_apply,
  input logic [2:0]       cmd_pend,
  input logic             acc_carry,
  input logic [SEC_W-1:0] time_sec,
  input logic [SUB_W-1:0] time_sub,
  input logic [SEC_W-1:0] upd_sec,
  input logic [SUB_W-1:0] upd_sub,
  input logic             reg_wr,
  input logic [2:0]       reg_addr
);

  logic [SUB_W:0] lim;
  logic           no_cmd;
  logic           ctrl_wr;

  assign lim     = digital_mode ? (SUB_W+1)'(NS_PER_SEC) : {1'b1, {SUB_W{1'b0}}};
  assign no_cmd  = !cmd_apply[0] && !cmd_apply[1];
  assign ctrl_wr = reg_wr && (reg_addr == 3'd0);

  AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fine_mode && no_cmd && (({1'b0, time_sub} + (SUB_W+1)'(incr)) < lim))
    |=> time_sub == $past(time_sub) + SUB_W'($past(incr))); // R2

  AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_mode && !acc_carry && no_cmd)
    |=> ($stable(time_sub) && $stable(time_sec))); // R3

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    no_cmd |=> (time_sec == $past(time_sec) || time_sec == $past(time_sec) + SEC_W'(1))); // R4

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_apply[0] |=> (time_sec == $past(upd_sec) && time_sub == $past(upd_sub))); // R6

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_apply[0] ##1 !ctrl_wr) |=> !cmd_pend[0]); // R9

endmodule

bind ptp_tod_counter ptp_tod_checker #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .NS_PER_SEC(NS_PER_SEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .fine_mode(fine_mode), .digital_mode(digital_mode), .incr(incr),
  .cmd_apply(cmd_apply), .cmd_pend(cmd_pend), .acc_carry(acc_carry),
  .time_sec(time_sec), .time_sub(time_sub), .upd_sec(upd_sec), .upd_sub(upd_sub),
  .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/ptp_tod_counter_test.sv
module ptp_tod_counter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  string       req_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];

  ptp_tod_counter uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  // monitor: pops expected items and compares with what the design produced
  always @(posedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      automatic string       r = req_q.pop_front();
      automatic logic [31:0] e = exp_q.pop_front();
      automatic logic [31:0] a = act_q.pop_front();
      compared++;
      if (a !== e) begin
        mismatched++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", r, a, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic expect_val(input string r, input logic [31:0] e, input logic [31:0] a);
    req_q.push_back(r);
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_clear(input int b);
    logic [31:0] c;
    for (int i = 0; i < 20; i++) begin
      rd(3'd0, c);
      if (!c[b]) break;
      @(negedge clk);
    end
  endtask

  task automatic chk(input string r, input logic [2:0] a, input logic [31:0] e);
    logic [31:0] d;
    rd(a, d);
    expect_val(r, e, d);
  endtask

  initial begin
    logic [31:0] va, vb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i <= 6; i++) chk("R1 reset", 3'(i), 32'd0);

    // R6 load, digital mode
    wr(3'd3, 32'd100);
    wr(3'd4, 32'd5000);
    wr(3'd0, 32'h6);
    chk("R9 load bit visible", 3'd0, 32'h6);
    wait_clear(2);
    chk("R6 load sub", 3'd5, 32'd5000);
    chk("R6 load sec", 3'd6, 32'd100);
    chk("R10 update seconds readback", 3'd3, 32'd100);

    // R7 add with carry
    wr(3'd3, 32'd2);
    wr(3'd4, 32'd999_999_000);
    wr(3'd0, 32'hA);
    wait_clear(3);
    chk("R7 add sub", 3'd5, 32'd4000);
    chk("R7 add sec", 3'd6, 32'd103);

    // R8 subtract with borrow
    wr(3'd3, 32'hFFFF_FFF6);
    wr(3'd4, 32'h8000_0000 | 32'd999_994_000);
    chk("R10 update sub readback", 3'd4, 32'h8000_0000 | 32'd999_994_000);
    wr(3'd0, 32'hA);
    wait_clear(3);
    chk("R8 borrow sub", 3'd5, 32'd999_998_000);
    chk("R8 borrow sec", 3'd6, 32'd92);

    // R8 subtract without borrow
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'h8000_0000 | 32'd999_999_000);
    wr(3'd0, 32'hA);
    wait_clear(3);
    chk("R8 no-borrow sub", 3'd5, 32'd999_997_000);
    chk("R8 no-borrow sec", 3'd6, 32'd91);

    // R2 coarse step
    wr(3'd1, 32'd8);
    chk("R10 increment readback", 3'd1, 32'd8);
    rd(3'd5, va);
    @(negedge clk);
    rd(3'd5, vb);
    expect_val("R2 coarse step", va + 32'd8, vb);
    wr(3'd1, 32'd0);

    // R4 digital rollover
    wr(3'd3, 32'd7);
    wr(3'd4, 32'd999_999_990);
    wr(3'd0, 32'h6);
    wait_clear(2);
    wr(3'd1, 32'd8);
    chk("R4 before step", 3'd5, 32'd999_999_990);
    @(negedge clk);
    chk("R4 last ns", 3'd5, 32'd999_999_998);
    chk("R4 sec held", 3'd6, 32'd7);
    @(negedge clk);
    chk("R4 wrap sub", 3'd5, 32'd6);
    chk("R4 wrap sec", 3'd6, 32'd8);
    wr(3'd1, 32'd0);

    // R5 binary rollover
    wr(3'd3, 32'd20);
    wr(3'd4, 32'h7FFF_FFFB);
    wr(3'd0, 32'h4);
    wait_clear(2);
    wr(3'd1, 32'd4);
    chk("R5 before step", 3'd5, 32'h7FFF_FFFB);
    @(negedge clk);
    chk("R5 top value", 3'd5, 32'h7FFF_FFFF);
    @(negedge clk);
    chk("R5 wrap sub", 3'd5, 32'd3);
    chk("R5 wrap sec", 3'd6, 32'd21);
    wr(3'd1, 32'd0);

    // R3 fine mode
    wr(3'd0, 32'h1);
    wr(3'd1, 32'd20);
    wr(3'd2, 32'h8000_0000);
    chk("R10 addend readback", 3'd2, 32'h8000_0000);
    rd(3'd5, va);
    repeat (4) @(negedge clk);
    rd(3'd5, vb);
    expect_val("R3 addend not yet applied", va, vb);
    wr(3'd0, 32'h11);
    wait_clear(4);
    rd(3'd5, va);
    repeat (8) @(negedge clk);
    rd(3'd5, vb);
    expect_val("R3 fine rate", va + 32'd80, vb);
    wr(3'd0, 32'h2);
    wr(3'd1, 32'd0);

    // R9 priority and pending
    wr(3'd3, 32'd50);
    wr(3'd4, 32'd0);
    wr(3'd0, 32'hE);
    chk("R9 both pending", 3'd0, 32'hE);
    wait_clear(2);
    chk("R9 adjust waits", 3'd0, 32'hA);
    chk("R9 load first", 3'd6, 32'd50);
    wait_clear(3);
    chk("R9 adjust after", 3'd6, 32'd100);
    chk("R7 zero sub", 3'd5, 32'd0);
    chk("R9 all clear", 3'd0, 32'h2);

    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule